// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt sources and presents them to a processor on two request lines, one for ordinary interrupts and one for fast interrupts. Each source carries an enable bit and a routing bit. The routing bit sends the source to either the normal path or the fast path. Each source also has a 4-bit priority. A software force register can raise any source with no hardware input. The processor sees everything through a simple 32-bit register port: one write strobe, a byte offset, write data, and combinational read data.

On the normal path, the controller picks the pending source with the highest priority among those that clear a priority mask threshold. It reports that source's number in a vector register, so an interrupt handler can read one register and branch to the correct service routine. On the fast path, the highest-numbered pending source is reported. The raw inputs and both pending bitmaps can also be read. Every bitmap is split into a low word (sources 0..31) and a high word (sources 32..63). All status and request outputs are registered together, so a read returns one coherent snapshot.

Top module: `vec_prio_intc`

## Requirements
- R1: After reset, the mask register reads 0x1F. The control, enable, type, force and priority registers read 0. Both vector registers read 0xFFFF0000. Both request lines are low.
- R2: Writing n (0..63) to offset 0x08 sets enable bit n, and writing n to offset 0x0C clears enable bit n. No other enable bit changes. A value above 63 changes nothing.
- R3: A source is pending when its input or its force bit is 1 and its enable bit is 1. Input sources are level-sensitive, so pending drops when the input falls. A pending source with type bit 0 appears in the normal-pending words (high 0x58, low 0x5C). A pending source with type bit 1 appears in the fast-pending words (high 0x60, low 0x64). The source words (high 0x48, low 0x4C) show the raw inputs only.
- R4: Source n takes its priority from bits [4*(n%8)+3 : 4*(n%8)] of the priority register at offset 0x20 + 4*(7 - n/8). Group 7 is at 0x20 and group 0 is at 0x3C.
- R5: The normal vector register (0x40) holds, in bits [31:16], the number of the eligible normal-pending source with the highest priority. Priority 15 is highest. On a tie, the higher source number wins. Bits [31:16] read 0xFFFF when no source is eligible. Bits [15:0] read 0.
- R6: A normal-pending source is eligible only if its priority is strictly greater than the 5-bit mask register (0x04). A mask of 0x1F therefore blocks every normal source.
- R7: irq_normal is high exactly when the normal vector holds a valid source. irq_fast is the OR of all fast-pending bits.
- R8: The fast vector register (0x44) holds, in bits [31:16], the highest-numbered fast-pending source. It reads 0xFFFF in those bits when none is pending.
- R9: Pending words, source words, vectors and request lines change one clock after the input or configuration change that causes them.
- R10: The enable-by-number and disable-by-number offsets read 0, as does any offset that is not in the map.
- R11: In the enable (0x10 high, 0x14 low), type (0x18 high, 0x1C low) and force (0x50 high, 0x54 low) words, the low word holds sources 0..31 and the high word holds sources 32..63. Bit k of a word is source k, or source 32+k in the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_in | input | 64 | Level interrupt inputs |
| irq_normal | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The bench targets the points a careless controller gets wrong. The first is equal priorities: a design that favours the lower number here would vector to the wrong source. The second is the mask threshold: a design that compares with "greater or equal" would still raise an interrupt when the priority equals the mask. The third is the reversed address order of the priority groups: a design that places group 0 at 0x20 would take the priority of source 63 from the wrong register. The bench also checks out-of-range numbers sent to the enable-by-number and disable-by-number registers, which a naive design would wrap onto low sources. It checks that the force bits are kept out of the raw source words. It checks the one-cycle latency by sampling before and after the edge that updates the outputs. Randomised configurations, compared against a bench model, cover how routing, enables and priorities combine.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
package ivc_pkg;
    localparam int NSRC    = 64;
    localparam int PRIO_W  = 4;
    localparam int MASK_W  = 5;
    localparam int PER_GRP = 32 / PRIO_W;
    localparam int NGRP    = NSRC / PER_GRP;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int ADDR_W  = 8;
    localparam logic [15:0] VEC_NONE = 16'hFFFF;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_SETNUM = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CLRNUM = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_ENH    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ENL    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_TYPH   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_TYPL   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_NVEC   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_FVEC   = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_SRCH   = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_SRCL   = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_FRCH   = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_FRCL   = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_NPH    = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_NPL    = 8'h5C;
    localparam logic [ADDR_W-1:0] OFS_FPH    = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_FPL    = 8'h64;

    // priority groups are laid out in descending group order
    function automatic logic [ADDR_W-1:0] grp_ofs(input int g);
        return ADDR_W'(32 + 4 * (NGRP - 1 - g));
    endfunction
endpackage

// File: rtl/ivc_regs.sv
`timescale 1ns/1ps
module ivc_regs
    import ivc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    output logic [NSRC-1:0]          en_o,
    output logic [NSRC-1:0]          typ_o,
    output logic [NSRC-1:0]          frc_o,
    output logic [NSRC*PRIO_W-1:0]   prio_o,
    output logic [MASK_W-1:0]        mask_o,
    input  logic [NSRC-1:0]          src_q,
    input  logic [NSRC-1:0]          npend_q,
    input  logic [NSRC-1:0]          fpend_q,
    input  logic [15:0]              nvec_q,
    input  logic [15:0]              fvec_q
);
    logic [31:0]       ctrl_q;
    logic [MASK_W-1:0] mask_q;
    logic [NSRC-1:0]   en_q, typ_q, frc_q;
    logic [31:0]       grp_q [NGRP];
    logic              num_ok;

    assign num_ok = (wdata[31:IDX_W] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '1;
            en_q   <= '0;
            typ_q  <= '0;
            frc_q  <= '0;
        end else if (wr) begin
            case (addr)
                OFS_CTRL:   ctrl_q <= wdata;
                OFS_MASK:   mask_q <= wdata[MASK_W-1:0];
                OFS_SETNUM: if (num_ok) en_q[wdata[IDX_W-1:0]] <= 1'b1;
                OFS_CLRNUM: if (num_ok) en_q[wdata[IDX_W-1:0]] <= 1'b0;
                OFS_ENH:    en_q[NSRC-1:32]  <= wdata;
                OFS_ENL:    en_q[31:0]       <= wdata;
                OFS_TYPH:   typ_q[NSRC-1:32] <= wdata;
                OFS_TYPL:   typ_q[31:0]      <= wdata;
                OFS_FRCH:   frc_q[NSRC-1:32] <= wdata;
                OFS_FRCL:   frc_q[31:0]      <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          grp_q[g] <= '0;
            else if (wr && addr == grp_ofs(g))   grp_q[g] <= wdata;
        end
        assign prio_o[g*32 +: 32] = grp_q[g];
    end

    always_comb begin
        case (addr)
            OFS_CTRL: rdata = ctrl_q;
            OFS_MASK: rdata = 32'(mask_q);
            OFS_ENH:  rdata = en_q[NSRC-1:32];
            OFS_ENL:  rdata = en_q[31:0];
            OFS_TYPH: rdata = typ_q[NSRC-1:32];
            OFS_TYPL: rdata = typ_q[31:0];
            OFS_NVEC: rdata = {nvec_q, 16'h0};
            OFS_FVEC: rdata = {fvec_q, 16'h0};
            OFS_SRCH: rdata = src_q[NSRC-1:32];
            OFS_SRCL: rdata = src_q[31:0];
            OFS_FRCH: rdata = frc_q[NSRC-1:32];
            OFS_FRCL: rdata = frc_q[31:0];
            OFS_NPH:  rdata = npend_q[NSRC-1:32];
            OFS_NPL:  rdata = npend_q[31:0];
            OFS_FPH:  rdata = fpend_q[NSRC-1:32];
            OFS_FPL:  rdata = fpend_q[31:0];
            default:  rdata = '0;
        endcase
        for (int g = 0; g < NGRP; g++)
            if (addr == grp_ofs(g)) rdata = grp_q[g];
    end

    assign en_o   = en_q;
    assign typ_o  = typ_q;
    assign frc_o  = frc_q;
    assign mask_o = mask_q;

    assert_setnum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_SETNUM && num_ok) |=> en_q[$past(wdata[IDX_W-1:0])]);
    assert_clrnum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_CLRNUM && num_ok) |=> !en_q[$past(wdata[IDX_W-1:0])]);
    assert_badnum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == OFS_SETNUM || addr == OFS_CLRNUM) && !num_ok) |=> $stable(en_q));
endmodule

// File: rtl/ivc_norm_arb.sv
`timescale 1ns/1ps
module ivc_norm_arb
    import ivc_pkg::*;
(
    input  logic [NSRC-1:0]        pend,
    input  logic [NSRC*PRIO_W-1:0] prio,
    input  logic [MASK_W-1:0]      mask,
    output logic [15:0]            vec,
    output logic                   valid
);
    logic [PRIO_W-1:0] p, best_p;
    logic [IDX_W-1:0]  best_i;
    logic              found;

    // ascending scan with >= lets the higher index win a tie
    always_comb begin
        best_p = '0;
        best_i = '0;
        found  = 1'b0;
        p      = '0;
        for (int i = 0; i < NSRC; i++) begin
            p = prio[i*PRIO_W +: PRIO_W];
            if (pend[i] && (MASK_W'(p) > mask) && (!found || p >= best_p)) begin
                best_p = p;
                best_i = IDX_W'(i);
                found  = 1'b1;
            end
        end
        valid = found;
        vec   = found ? 16'(best_i) : VEC_NONE;
    end
endmodule

// File: rtl/ivc_fast_pick.sv
`timescale 1ns/1ps
module ivc_fast_pick
    import ivc_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    output logic [15:0]     vec
);
    always_comb begin
        vec = VEC_NONE;
        for (int i = 0; i < NSRC; i++)
            if (pend[i]) vec = 16'(i);
    end
endmodule

// File: rtl/vec_prio_intc.sv
`timescale 1ns/1ps
module vec_prio_intc
    import ivc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [7:0]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    input  logic [63:0]  src_in,
    output logic         irq_normal,
    output logic         irq_fast
);
    logic [NSRC-1:0]        en, typ, frc;
    logic [NSRC*PRIO_W-1:0] prio;
    logic [MASK_W-1:0]      mask;
    logic [NSRC-1:0]        live, npend_c, fpend_c;
    logic [NSRC-1:0]        src_q, npend_q, fpend_q;
    logic [15:0]            nvec_c, fvec_c, nvec_q, fvec_q;
    logic                   nvalid_c, irqn_q, irqf_q;

    ivc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .en_o(en), .typ_o(typ), .frc_o(frc), .prio_o(prio), .mask_o(mask),
        .src_q(src_q), .npend_q(npend_q), .fpend_q(fpend_q),
        .nvec_q(nvec_q), .fvec_q(fvec_q)
    );

    assign live    = (src_in | frc) & en;
    assign npend_c = live & ~typ;
    assign fpend_c = live & typ;

    ivc_norm_arb u_narb (
        .pend(npend_c), .prio(prio), .mask(mask), .vec(nvec_c), .valid(nvalid_c)
    );

    ivc_fast_pick u_fpick (.pend(fpend_c), .vec(fvec_c));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= '0;
            npend_q <= '0;
            fpend_q <= '0;
            nvec_q  <= VEC_NONE;
            fvec_q  <= VEC_NONE;
            irqn_q  <= 1'b0;
            irqf_q  <= 1'b0;
        end else begin
            src_q   <= src_in;
            npend_q <= npend_c;
            fpend_q <= fpend_c;
            nvec_q  <= nvec_c;
            fvec_q  <= fvec_c;
            irqn_q  <= nvalid_c;
            irqf_q  <= |fpend_c;
        end
    end

    assign irq_normal = irqn_q;
    assign irq_fast   = irqf_q;

    assert_irqn_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_normal == (nvec_q != VEC_NONE));
    assert_irqf_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast == (fpend_q != '0));
    assert_nvec_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nvec_q != VEC_NONE) |-> npend_q[nvec_q[IDX_W-1:0]]);
    assert_fvec_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fpend_q == '0) == (fvec_q == VEC_NONE));
    assert_paths_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (npend_q & fpend_q) == '0);
endmodule

// File: tb/sim_vec_prio_intc.sv
`timescale 1ns/1ps
module sim_vec_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        irq_normal, irq_fast;

    int nchk = 0, nfail = 0;
    bit done = 0;

    logic [63:0] m_en = '0, m_typ = '0, m_frc = '0;
    logic [31:0] m_grp [8];
    logic [4:0]  m_mask = 5'h1F;

    vec_prio_intc u0 (.*);

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            8'h04: m_mask = d[4:0];
            8'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
            8'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
            8'h10: m_en[63:32] = d;
            8'h14: m_en[31:0] = d;
            8'h18: m_typ[63:32] = d;
            8'h1C: m_typ[31:0] = d;
            8'h50: m_frc[63:32] = d;
            8'h54: m_frc[31:0] = d;
            default: if (a >= 8'h20 && a <= 8'h3C) m_grp[7 - ((a - 8'h20) >> 2)] = d;
        endcase
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    function automatic logic [63:0] f_live();
        return (src_in | m_frc) & m_en;
    endfunction

    function automatic logic [15:0] f_nvec();
        logic [15:0] best = 16'hFFFF;
        int bp = -1;
        logic [63:0] np = f_live() & ~m_typ;
        for (int n = 0; n < 64; n++) begin
            int p = int'(m_grp[n / 8][4 * (n % 8) +: 4]);
            if (np[n] && p > int'(m_mask) && p >= bp) begin
                bp = p; best = 16'(n);
            end
        end
        return best;
    endfunction

    function automatic logic [15:0] f_fvec();
        logic [15:0] best = 16'hFFFF;
        logic [63:0] fp = f_live() & m_typ;
        for (int n = 0; n < 64; n++) if (fp[n]) best = 16'(n);
        return best;
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] d;
        logic [63:0] np = f_live() & ~m_typ;
        logic [63:0] fp = f_live() & m_typ;
        rd(8'h40, d); chk({tag, " R5 nvec"}, d, {f_nvec(), 16'h0});
        rd(8'h44, d); chk({tag, " R8 fvec"}, d, {f_fvec(), 16'h0});
        rd(8'h5C, d); chk({tag, " R3 npend lo"}, d, np[31:0]);
        rd(8'h58, d); chk({tag, " R3 npend hi"}, d, np[63:32]);
        rd(8'h64, d); chk({tag, " R3 fpend lo"}, d, fp[31:0]);
        rd(8'h60, d); chk({tag, " R3 fpend hi"}, d, fp[63:32]);
        rd(8'h4C, d); chk({tag, " R3 src lo"}, d, src_in[31:0]);
        rd(8'h48, d); chk({tag, " R3 src hi"}, d, src_in[63:32]);
        chk({tag, " R7 irq_normal"}, 32'(irq_normal), 32'(f_nvec() != 16'hFFFF));
        chk({tag, " R7 irq_fast"}, 32'(irq_fast), 32'(fp != 0));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int g = 0; g < 8; g++) m_grp[g] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h04, d); chk("R1 mask", d, 32'h1F);
        rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h14, d); chk("R1 enable lo", d, 32'h0);
        rd(8'h2C, d); chk("R1 prio grp", d, 32'h0);
        rd(8'h40, d); chk("R1 nvec", d, 32'hFFFF0000);
        rd(8'h44, d); chk("R1 fvec", d, 32'hFFFF0000);
        chk("R1 irq_normal", 32'(irq_normal), 0);
        chk("R1 irq_fast", 32'(irq_fast), 0);

        // R2 / R11 enable by number
        bw(8'h08, 5); bw(8'h08, 40); bw(8'h08, 64);
        rd(8'h14, d); chk("R2 R11 enable lo", d, 32'h20);
        rd(8'h10, d); chk("R2 R11 enable hi", d, 32'h100);
        bw(8'h0C, 5); bw(8'h0C, 100); bw(8'h08, 32'h1_0001);
        rd(8'h14, d); chk("R2 clear lo", d, 32'h0);
        rd(8'h10, d); chk("R2 keep hi", d, 32'h100);

        // R10 reads of write-only and unmapped offsets
        rd(8'h08, d); chk("R10 setnum read", d, 0);
        rd(8'h0C, d); chk("R10 clrnum read", d, 0);
        rd(8'h68, d); chk("R10 unmapped 68", d, 0);
        rd(8'h7C, d); chk("R10 unmapped 7C", d, 0);

        // R4 group layout: source 1 in group 0 at 0x3C, source 63 in group 7 at 0x20
        bw(8'h3C, 32'h0000_00A0);
        rd(8'h3C, d); chk("R4 grp0 readback", d, 32'h0000_00A0);
        bw(8'h20, 32'hF000_0000);
        bw(8'h04, 0);
        bw(8'h08, 1);
        src_in = 64'h2;
        settle();
        rd(8'h40, d); chk("R4 R5 nvec src1", d, 32'h0001_0000);
        chk("R7 irq_normal on", 32'(irq_normal), 1);
        bw(8'h08, 63);
        src_in = 64'h8000_0000_0000_0002;
        settle();
        rd(8'h40, d); chk("R4 R5 nvec src63", d, 32'h003F_0000);

        // R5 tie: sources 1 and 2 at priority 10, higher number wins
        bw(8'h3C, 32'h0000_0AA0); bw(8'h08, 2);
        src_in = 64'h6;
        settle();
        rd(8'h40, d); chk("R5 tie", d, 32'h0002_0000);

        // R6 mask threshold is strict
        bw(8'h04, 10); settle();
        rd(8'h40, d); chk("R6 mask equal", d, 32'hFFFF_0000);
        chk("R6 R7 irq_normal off", 32'(irq_normal), 0);
        bw(8'h04, 9); settle();
        rd(8'h40, d); chk("R6 mask below", d, 32'h0002_0000);
        bw(8'h04, 31); settle();
        rd(8'h40, d); chk("R6 mask 1F", d, 32'hFFFF_0000);
        bw(8'h04, 0);

        // R8 fast routing
        bw(8'h1C, 32'h6); settle();
        rd(8'h44, d); chk("R8 fvec", d, 32'h0002_0000);
        rd(8'h64, d); chk("R3 fpend lo", d, 32'h6);
        rd(8'h5C, d); chk("R3 npend lo", d, 32'h0);
        chk("R7 irq_fast on", 32'(irq_fast), 1);
        bw(8'h18, 32'h8000_0000);
        src_in = 64'h8000_0000_0000_0006;
        settle();
        rd(8'h44, d); chk("R8 R11 fvec src63", d, 32'h003F_0000);

        // R3 force and level behaviour
        src_in = '0;
        bw(8'h54, 32'h2); settle();
        rd(8'h64, d); chk("R3 force pend", d, 32'h2);
        rd(8'h4C, d); chk("R3 source excludes force", d, 32'h0);
        rd(8'h44, d); chk("R8 fvec forced", d, 32'h0001_0000);
        bw(8'h54, 0);
        src_in[63] = 1'b1; settle();
        rd(8'h60, d); chk("R3 level high", d, 32'h8000_0000);
        src_in[63] = 1'b0; settle();
        rd(8'h60, d); chk("R3 level drop", d, 32'h0);

        // R9 one-cycle latency
        src_in = 64'h4;
        #1; chk("R9 before edge", 32'(irq_fast), 0);
        @(negedge clk);
        chk("R9 after edge", 32'(irq_fast), 1);
        src_in = '0;
        settle();

        // random configurations
        for (int it = 0; it < 250; it++) begin
            bw(8'h14, $urandom); bw(8'h10, $urandom);
            bw(8'h1C, $urandom & $urandom); bw(8'h18, $urandom & $urandom);
            bw(8'h54, $urandom & $urandom & $urandom);
            bw(8'h50, $urandom & $urandom & $urandom);
            for (int g = 0; g < 8; g++) bw(8'(32 + 4 * g), $urandom);
            bw(8'h04, ($urandom % 8 == 0) ? 32'h1F : ($urandom % 16));
            src_in = {$urandom, $urandom} & {$urandom, $urandom};
            settle();
            check_all("random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule